// File: doc/BRIEF.md
# Serial Memory Write-Protection Guard

This block keeps the protection state of a serial-interface memory and decides, cycle by cycle, whether a status-register update or an array write may go ahead. The serial front end feeds it decoded command strobes, a strobe for the start of a transaction (chip select falling), a strobe for its end (chip select rising), the byte intended for the status register, the level of the active-low hardware write-protect pin, and the address of the array write being considered. The block returns the status byte for read-back and two grant lines.

Commands take effect when the transaction that carries them ends. Set-enable and clear-enable commands drive a write-enable latch. A status write can change a protect-enable bit and a two-bit region selector. The selector protects nothing, the top quarter, the top half or the whole array. The pin is captured when a transaction starts. Status updates are blocked only when protect-enable is set and the captured pin is low. A pin change later in the transaction has no effect.

Top module: `wp_guard`

## Requirements
- R1: After reset the status byte is 0x00 and both grants are low.
- R2: A set-enable command (opcode 0x06, strobe `cmd_wren_i`) sets the write-enable latch (status bit 1) in the cycle after the transaction-end strobe, and not before.
- R3: A clear-enable command (opcode 0x04, strobe `cmd_wrdi_i`) clears the write-enable latch in the cycle after the transaction-end strobe.
- R4: While the write-enable latch is 0, both grants are low and a status write leaves the status byte unchanged.
- R5: With region selector (status bits 3:2) 01 the addresses 0x18000–0x1FFFF are refused, with 10 the addresses 0x10000–0x1FFFF are refused, and with 11 every address is refused, whatever the latch holds.
- R6: With the latch set and the address outside the selected region (every address for selector 00), the array grant is high.
- R7: With protect-enable (status bit 7) at 1 and the pin low when the transaction started, the status grant is low and a status write changes neither bit 7 nor bits 3:2.
- R8: With protect-enable at 0, the pin level has no effect on the status grant.
- R9: A pin that falls after the transaction start does not block a status write in that transaction.
- R10: A granted status write copies data bit 7 to protect-enable and data bits 3:2 to the selector. Status bits 6:4 and bit 0 always read 0.
- R11: The write-enable latch clears at the end of every status-write or array-write transaction.
- R12: Status bits 7 and 3:2 change only in the cycle after a transaction-end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start_i | input | 1 | Transaction start strobe (chip select falling) |
| txn_end_i | input | 1 | Transaction end strobe (chip select rising) |
| cmd_wren_i | input | 1 | Set-enable command decoded |
| cmd_wrdi_i | input | 1 | Clear-enable command decoded |
| cmd_wrsr_i | input | 1 | Status-write command decoded |
| cmd_write_i | input | 1 | Array-write command decoded |
| sr_wdata_i | input | 8 | Byte for the status register, valid at the end strobe |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| arr_addr_i | input | ADDR_W | Address of the array write under consideration |
| status_o | output | 8 | Status byte for read-back |
| sr_grant_o | output | 1 | Status-register write allowed |
| arr_grant_o | output | 1 | Array write allowed |

## Verification
The bench sets each region selector and probes the addresses on both sides of every boundary (0x17FFF/0x18000 and 0x0FFFF/0x10000). A design with a wrong decode would grant a protected word or refuse a free one. It runs a status write with the pin low at the start and another with the pin falling mid-transaction. A design that reads the live pin would refuse the second, and one that ignores the pin would accept the first. It also checks that the latch rises only after the end strobe and clears after every write transaction. A design that updates early, or that leaves the latch set, shows a wrong status byte at the mid-transaction sample or after the end.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int SR_W        = 8;
    localparam int SR_WPEN_BIT = 7;
    localparam int SR_BP_LSB   = 2;
    localparam int SR_WEL_BIT  = 1;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WREN  = 3'd1,
        OP_WRDI  = 3'd2,
        OP_WRSR  = 3'd3,
        OP_WRITE = 3'd4
    } pend_op_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wel;
        logic       wp_lat;
        pend_op_e   op;
    } prot_st_t;

endpackage

// File: rtl/wp_region_chk.sv
module wp_region_chk #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        case (bp_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = addr_i[TOP] & addr_i[TOP-1];
            2'b10:   hit_o = addr_i[TOP];
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_grant_calc.sv
module wp_grant_calc (
    input  logic wel_i,
    input  logic wpen_i,
    input  logic wp_lat_i,
    input  logic region_hit_i,
    output logic sr_ok_o,
    output logic arr_ok_o
);
    logic pin_block;

    always_comb begin
        pin_block = wpen_i & ~wp_lat_i;
        sr_ok_o   = wel_i & ~pin_block;
        arr_ok_o  = wel_i & ~region_hit_i;
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start_i,
    input  logic              txn_end_i,
    input  logic              cmd_wren_i,
    input  logic              cmd_wrdi_i,
    input  logic              cmd_wrsr_i,
    input  logic              cmd_write_i,
    input  logic [SR_W-1:0]   sr_wdata_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    output logic [SR_W-1:0]   status_o,
    output logic              sr_grant_o,
    output logic              arr_grant_o
);
    prot_st_t st_d, st_q;
    logic     region_hit;
    logic     sr_ok;
    logic     arr_ok;

    wp_region_chk #(.ADDR_W(ADDR_W)) u_region (
        .bp_i   (st_q.bp),
        .addr_i (arr_addr_i),
        .hit_o  (region_hit)
    );

    wp_grant_calc u_grant (
        .wel_i        (st_q.wel),
        .wpen_i       (st_q.wpen),
        .wp_lat_i     (st_q.wp_lat),
        .region_hit_i (region_hit),
        .sr_ok_o      (sr_ok),
        .arr_ok_o     (arr_ok)
    );

    always_comb begin
        st_d = st_q;
        if (txn_start_i) begin
            st_d.wp_lat = wp_n_i;
            st_d.op     = OP_NONE;
        end
        if (cmd_wren_i)       st_d.op = OP_WREN;
        else if (cmd_wrdi_i)  st_d.op = OP_WRDI;
        else if (cmd_wrsr_i)  st_d.op = OP_WRSR;
        else if (cmd_write_i) st_d.op = OP_WRITE;
        if (txn_end_i) begin
            case (st_q.op)
                OP_WREN: st_d.wel = 1'b1;
                OP_WRDI: st_d.wel = 1'b0;
                OP_WRSR: begin
                    if (sr_ok) begin
                        st_d.wpen = sr_wdata_i[SR_WPEN_BIT];
                        st_d.bp   = sr_wdata_i[SR_BP_LSB +: 2];
                    end
                    st_d.wel = 1'b0;
                end
                OP_WRITE: st_d.wel = 1'b0;
                default:  st_d.wel = st_q.wel;
            endcase
            st_d.op = OP_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wpen: 1'b0, bp: 2'b00, wel: 1'b0, wp_lat: 1'b0, op: OP_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o                 = '0;
        status_o[SR_WPEN_BIT]    = st_q.wpen;
        status_o[SR_BP_LSB +: 2] = st_q.bp;
        status_o[SR_WEL_BIT]     = st_q.wel;
        sr_grant_o               = sr_ok;
        arr_grant_o              = arr_ok;
    end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_end_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic [7:0]        status_o,
    input logic              sr_grant_o,
    input logic              arr_grant_o
);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QUAR_BASE = ADDR_W'(3) << (ADDR_W - 2);

    logic in_range;
    always_comb begin
        in_range = (status_o[3:2] == 2'b11)
                || (status_o[3:2] == 2'b10 && arr_addr_i >= HALF_BASE)
                || (status_o[3:2] == 2'b01 && arr_addr_i >= QUAR_BASE);
    end

    assert_no_grant_wo_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> (!sr_grant_o && !arr_grant_o));

    assert_region_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_range |-> !arr_grant_o);

    assert_wel_rise_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[1]) |-> $past(txn_end_i));

    assert_cfg_only_at_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(txn_end_i) |-> $stable({status_o[7], status_o[3:2]}));

    assert_fixed_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[6:4] == 3'b000) && !status_o[0]);
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_end_i   (txn_end_i),
    .arr_addr_i  (arr_addr_i),
    .status_o    (status_o),
    .sr_grant_o  (sr_grant_o),
    .arr_grant_o (arr_grant_o)
);

// File: tb/wp_guard_tb.sv
module wp_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              txn_start_i = 1'b0, txn_end_i = 1'b0;
    logic              cmd_wren_i = 1'b0, cmd_wrdi_i = 1'b0;
    logic              cmd_wrsr_i = 1'b0, cmd_write_i = 1'b0;
    logic [7:0]        sr_wdata_i = 8'h00;
    logic              wp_n_i = 1'b1;
    logic [ADDR_W-1:0] arr_addr_i = '0;
    logic [7:0]        status_o;
    logic              sr_grant_o, arr_grant_o;

    typedef struct {
        string      req;
        logic [7:0] st;
        logic       srg;
        logic       arg;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .txn_start_i(txn_start_i), .txn_end_i(txn_end_i),
        .cmd_wren_i(cmd_wren_i), .cmd_wrdi_i(cmd_wrdi_i),
        .cmd_wrsr_i(cmd_wrsr_i), .cmd_write_i(cmd_write_i),
        .sr_wdata_i(sr_wdata_i), .wp_n_i(wp_n_i), .arr_addr_i(arr_addr_i),
        .status_o(status_o), .sr_grant_o(sr_grant_o), .arr_grant_o(arr_grant_o)
    );

    // monitor: drains the scoreboard one time unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (status_o !== e.st || sr_grant_o !== e.srg || arr_grant_o !== e.arg) begin
                    n_fail++;
                    $display("FAIL %s: got st=%02h srg=%0b arg=%0b, expected st=%02h srg=%0b arg=%0b",
                             e.req, status_o, sr_grant_o, arr_grant_o, e.st, e.srg, e.arg);
                end
            end
        end
    end

    task automatic expect_now(input string req, input logic [7:0] st,
                              input logic srg, input logic arg);
        exp_t e;
        e.req = req; e.st = st; e.srg = srg; e.arg = arg;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic begin_txn(input logic pin);
        @(negedge clk);
        wp_n_i = pin; txn_start_i = 1'b1;
        @(negedge clk);
        txn_start_i = 1'b0;
    endtask

    task automatic send_cmd(input int op, input logic [7:0] data);
        sr_wdata_i = data;
        case (op)
            0: cmd_wren_i  = 1'b1;
            1: cmd_wrdi_i  = 1'b1;
            2: cmd_wrsr_i  = 1'b1;
            default: cmd_write_i = 1'b1;
        endcase
        @(negedge clk);
        cmd_wren_i = 1'b0; cmd_wrdi_i = 1'b0; cmd_wrsr_i = 1'b0; cmd_write_i = 1'b0;
    endtask

    task automatic end_txn();
        txn_end_i = 1'b1;
        @(negedge clk);
        txn_end_i = 1'b0;
    endtask

    task automatic full_txn(input int op, input logic [7:0] data, input logic pin);
        begin_txn(pin);
        send_cmd(op, data);
        end_txn();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset", 8'h00, 1'b0, 1'b0);

        // set-enable: nothing before end, latch after
        begin_txn(1'b1);
        send_cmd(0, 8'h00);
        expect_now("R2 before end", 8'h00, 1'b0, 1'b0);
        end_txn();
        arr_addr_i = 17'h1FFFF;
        expect_now("R2/R6 after end, selector 00", 8'h02, 1'b1, 1'b1);

        full_txn(1, 8'h00, 1'b1);
        expect_now("R3 clear-enable", 8'h00, 1'b0, 1'b0);

        full_txn(2, 8'h8C, 1'b1);
        expect_now("R4 status write refused with latch 0", 8'h00, 1'b0, 1'b0);

        full_txn(0, 8'h00, 1'b1);
        full_txn(2, 8'hF7, 1'b1);
        expect_now("R10/R11 status write 0xF7", 8'h84, 1'b0, 1'b0);

        full_txn(0, 8'h00, 1'b1);
        arr_addr_i = 17'h17FFF;
        expect_now("R6 selector 01 below quarter", 8'h86, 1'b1, 1'b1);
        arr_addr_i = 17'h18000;
        expect_now("R5 selector 01 quarter base", 8'h86, 1'b1, 1'b0);

        begin_txn(1'b0);
        send_cmd(2, 8'h08);
        expect_now("R7 pin low at start blocks grant", 8'h86, 1'b0, 1'b0);
        end_txn();
        expect_now("R7 status write had no effect", 8'h84, 1'b0, 1'b0);

        full_txn(0, 8'h00, 1'b0);
        begin_txn(1'b1);
        send_cmd(2, 8'h88);
        wp_n_i = 1'b0;
        @(negedge clk);
        end_txn();
        expect_now("R9 pin falling mid-transaction ignored", 8'h88, 1'b0, 1'b0);

        full_txn(0, 8'h00, 1'b1);
        arr_addr_i = 17'h10000;
        expect_now("R5 selector 10 half base", 8'h8A, 1'b1, 1'b0);
        arr_addr_i = 17'h0FFFF;
        expect_now("R6 selector 10 below half", 8'h8A, 1'b1, 1'b1);

        full_txn(2, 8'h0C, 1'b1);
        full_txn(0, 8'h00, 1'b1);
        arr_addr_i = 17'h00000;
        expect_now("R5 selector 11 all refused", 8'h0E, 1'b1, 1'b0);

        begin_txn(1'b0);
        expect_now("R8 pin low ignored with protect-enable 0", 8'h0E, 1'b1, 1'b0);
        send_cmd(2, 8'h00);
        expect_now("R12 no change before end", 8'h0E, 1'b1, 1'b0);
        end_txn();
        expect_now("R8 status write applied", 8'h00, 1'b0, 1'b0);

        full_txn(0, 8'h00, 1'b1);
        full_txn(3, 8'h00, 1'b1);
        expect_now("R11 array write clears latch", 8'h00, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule